// File: doc/BRIEF.md
# Serial Flash Protection and Shared-Pin Role Control

This block sits beside the status register and the serial shifter of a serial flash device. It makes two kinds of decision. The first is whether a status register write may change the protection-related bits. The second is what the two shared control pins currently mean: each is either a plain data line or a control input (pause or reset). From these decisions it produces the effective pause and reset levels, an enable for the serial data output, and a transfer bit counter. The counter pauses while the transfer is held and resumes later without losing its place.

The sticky lock bit and the protect pin level together form the hardware write lock. When quad mode is on, the protect pin carries data and the lock is released. When quad mode is off, a role-select bit decides whether the fourth pin acts as a pause input or as a reset input. A strap marks the variant with its own reset pin. On that variant the fourth pin is always the pause input, and the separate reset pin acts on its own.

Top module: `flash_pin_guard`

## Requirements
- R1: After rst_n is released, wr_ok is 1 and xfer_cnt is 0.
- R2: On a cycle with wr_done=1, lock_bit=1, quad_bit=0 and prot_pin=0, wr_ok becomes 0 on the next cycle.
- R3: On a cycle with wr_done=1 and lock_bit=0, wr_ok becomes 1 on the next cycle, whatever prot_pin is.
- R4: On a cycle with wr_done=1 and quad_bit=1, wr_ok becomes 1 on the next cycle, because prot_pin serves as data and is ignored.
- R5: wr_ok changes only on the cycle after a wr_done pulse. Changes to lock_bit, quad_bit and prot_pin with wr_done=0 leave it unchanged.
- R6: hold_act is 1 exactly when cs_n=0, quad_bit=0, aux_pin=0, and either role_sel=0 or ded_strap=1.
- R7: When ded_strap=0, rst_act is 1 exactly when quad_bit=0, role_sel=1 and aux_pin=0.
- R8: When ded_strap=1, rst_act equals the inverse of ded_rst_n, whatever quad_bit and role_sel are. When ded_strap=0, ded_rst_n has no effect on any output.
- R9: dout_en is 1 exactly when cs_n=0, hold_act=0 and rst_act=0.
- R10: xfer_cnt increments by one on each clock edge where dout_en is 1. It holds its value while hold_act=1. It clears to 0 on an edge where cs_n=1 or rst_act=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip select, active low |
| prot_pin | input | 1 | Level of the write-protect / data line 2 pin |
| aux_pin | input | 1 | Level of the shared pause-or-reset / data line 3 pin |
| ded_rst_n | input | 1 | Level of the dedicated reset pin, active low |
| ded_strap | input | 1 | 1 on the variant with a dedicated reset pin |
| lock_bit | input | 1 | Sticky status register write lock bit |
| quad_bit | input | 1 | Quad mode enable bit |
| role_sel | input | 1 | Shared pin role: 0 pause, 1 reset |
| wr_done | input | 1 | Pulse marking completion of a status register write command |
| wr_ok | output | 1 | Protected status bits may be written |
| hold_act | output | 1 | Effective pause, active high |
| rst_act | output | 1 | Effective device reset, active high |
| dout_en | output | 1 | Serial data output enable |
| xfer_cnt | output | CNT_W | Transfer bit counter |

## Verification
The pin-role logic is swept over all 64 combinations of chip select, quad bit, role select, shared pin, dedicated reset pin and strap. This separates the pause role from the reset role and the shared-reset variant from the dedicated-reset variant, and it shows that an unselected chip never pauses. The write lock is tried with all eight combinations of lock bit, quad bit and protect pin at a completion pulse. The bench then changes those inputs without a pulse to show that the flag is latched and not live. The counter is run, paused, resumed, deselected and reset, so that a pause which lost progress can be told apart from one that kept it.

// File: rtl/flash_pin_guard.sv
module flash_pin_guard #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             prot_pin,
  input  logic             aux_pin,
  input  logic             ded_rst_n,
  input  logic             ded_strap,
  input  logic             lock_bit,
  input  logic             quad_bit,
  input  logic             role_sel,
  input  logic             wr_done,
  output logic             wr_ok,
  output logic             hold_act,
  output logic             rst_act,
  output logic             dout_en,
  output logic [CNT_W-1:0] xfer_cnt
);

  logic aux_is_hold, aux_is_rst, hw_locked;

  assign aux_is_hold = !quad_bit && (ded_strap || !role_sel);
  assign aux_is_rst  = !quad_bit && !ded_strap && role_sel;
  assign hw_locked   = lock_bit && !quad_bit && !prot_pin;

  assign hold_act = aux_is_hold && !aux_pin && !cs_n;
  assign rst_act  = ded_strap ? !ded_rst_n : (aux_is_rst && !aux_pin);
  assign dout_en  = !cs_n && !hold_act && !rst_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wr_ok <= 1'b1;
    else if (wr_done) wr_ok <= !hw_locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                xfer_cnt <= '0;
    else if (cs_n || rst_act)  xfer_cnt <= '0;
    else if (!hold_act)        xfer_cnt <= xfer_cnt + 1'b1;
  end

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && lock_bit && !quad_bit && !prot_pin) |=> !wr_ok); // R2
  AST_UNLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && !lock_bit) |=> wr_ok); // R3
  AST_QUAD_FREES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && quad_bit) |=> wr_ok); // R4
  AST_FLAG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done |=> $stable(wr_ok)); // R5
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_act && !rst_act) |=> $stable(xfer_cnt)); // R10
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (xfer_cnt == '0)); // R10

  always_comb begin
    if (rst_n && !ded_strap) begin
      AST_SHARED_ROLE_EXCL: assert (!(hold_act && rst_act)); // R7
    end
  end

endmodule

// File: tb/flash_pin_guard_tb_top.sv
module flash_pin_guard_tb_top;
  localparam int PERIOD = 10;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, prot_pin = 1'b1, aux_pin = 1'b1, ded_rst_n = 1'b1, ded_strap = 1'b0;
  logic lock_bit = 1'b0, quad_bit = 1'b0, role_sel = 1'b0, wr_done = 1'b0;
  logic wr_ok, hold_act, rst_act, dout_en;
  logic [CNT_W-1:0] xfer_cnt;

  int checks = 0;
  int failures = 0;

  always #(PERIOD/2) clk = ~clk;

  flash_pin_guard #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .prot_pin(prot_pin), .aux_pin(aux_pin),
    .ded_rst_n(ded_rst_n), .ded_strap(ded_strap), .lock_bit(lock_bit),
    .quad_bit(quad_bit), .role_sel(role_sel), .wr_done(wr_done),
    .wr_ok(wr_ok), .hold_act(hold_act), .rst_act(rst_act), .dout_en(dout_en),
    .xfer_cnt(xfer_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #(PERIOD*100000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 wr_ok", wr_ok, 1);
    check("R1 xfer_cnt", xfer_cnt, 0);

    // R6 R7 R8 R9: exhaustive pin-role sweep
    for (int v = 0; v < 64; v++) begin
      bit e_hold, e_rst, e_oe;
      @(negedge clk);
      {cs_n, quad_bit, role_sel, aux_pin, ded_rst_n, ded_strap} = 6'(v);
      #1;
      e_hold = !cs_n && !quad_bit && !aux_pin && (!role_sel || ded_strap);
      e_rst  = ded_strap ? !ded_rst_n : (!quad_bit && role_sel && !aux_pin);
      e_oe   = !cs_n && !e_hold && !e_rst;
      check("R6 hold_act", hold_act, e_hold);
      check(ded_strap ? "R8 rst_act" : "R7 rst_act", rst_act, e_rst);
      check("R9 dout_en", dout_en, e_oe);
    end

    // R2 R3 R4: lock sweep at completion pulse
    @(negedge clk);
    cs_n = 1'b1; ded_strap = 1'b0; ded_rst_n = 1'b1; aux_pin = 1'b1; role_sel = 1'b0;
    for (int v = 0; v < 8; v++) begin
      bit e_ok;
      {lock_bit, quad_bit, prot_pin} = 3'(v);
      wr_done = 1'b1;
      @(negedge clk);
      wr_done = 1'b0;
      e_ok = !(lock_bit && !quad_bit && !prot_pin);
      check(!lock_bit ? "R3 wr_ok" : (quad_bit ? "R4 wr_ok" : "R2 wr_ok"), wr_ok, e_ok);
    end

    // R5: flag latched between pulses
    lock_bit = 1'b1; quad_bit = 1'b0; prot_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 no pulse keeps 1", wr_ok, 1);
    wr_done = 1'b1;
    @(negedge clk);
    wr_done = 1'b0;
    check("R2 blocked", wr_ok, 0);
    lock_bit = 1'b0; prot_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 no pulse keeps 0", wr_ok, 0);

    // R10: counter run, pause, resume, deselect, reset
    quad_bit = 1'b0; role_sel = 1'b0; aux_pin = 1'b1; ded_strap = 1'b0;
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 run", xfer_cnt, 5);
    aux_pin = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 held", xfer_cnt, 5);
    check("R9 held oe", dout_en, 0);
    aux_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 resume", xfer_cnt, 7);
    cs_n = 1'b1;
    @(negedge clk);
    check("R10 deselect", xfer_cnt, 0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    role_sel = 1'b1; aux_pin = 1'b0;
    @(negedge clk);
    check("R10 shared reset clears", xfer_cnt, 0);
    check("R7 reset active", rst_act, 1);
    aux_pin = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 after reset", xfer_cnt, 3);
    ded_rst_n = 1'b0;
    @(negedge clk);
    check("R8 dedicated pin ignored", xfer_cnt, 4);
    check("R8 rst_act ignored", rst_act, 0);
    ded_strap = 1'b1; quad_bit = 1'b1;
    @(negedge clk);
    check("R8 dedicated clears", xfer_cnt, 0);
    check("R8 quad independent", rst_act, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule